// File: doc/BRIEF.md
# Timer Channel Count and Status Readback Path

This block is the processor-facing read side of one timer channel. It takes the live 16-bit count from the counting logic, the channel's output level, its null-count flag and the six stored configuration bits. It turns them into the byte that a read of that channel returns. A count snapshot register follows the live count until a latch-count strobe freezes it. The frozen value stays in place until the processor has read it completely in the programmed byte format. A separate status snapshot captures the output level, the null-count flag and the configuration bits when a latch-status strobe arrives.

Repeated latch strobes have no effect while a snapshot is still unread. A latched status is always returned before any count byte. In the two-byte format a byte pointer steps from the low byte to the high byte on each count read. A program strobe, which marks a new configuration word for this channel, releases any frozen count and sets the pointer back to the low byte. The counting itself and the bus drivers are outside this block.

Top module: `cnt_readback_path`

## Requirements
- R1: After reset no count or status is held and the byte pointer selects the low byte, so with the two-byte format `rd_data_o` shows bits 7..0 of `live_cnt_i`.
- R2: While no count is held and no status is held, `rd_data_o` shows the live count. Its byte is chosen by the format field `cfg_i[5:4]`: 01 selects the low byte only, 10 selects the high byte only, and 11 (and 00) selects the two-byte sequence.
- R3: A `latch_cnt_i` pulse while no count is held captures `live_cnt_i` from that clock edge. Reads then return the captured bytes whatever the live count does, until the count has been fully read. After that, reads follow the live count again.
- R4: A `latch_cnt_i` pulse while a count is already held is ignored. The bytes read afterwards come from the first capture.
- R5: The latched status byte is the output level in bit 7, the null-count flag in bit 6 and `cfg_i[5:0]` in bits 5..0, all sampled at the latch edge.
- R6: A `latch_sts_i` pulse while a status is already held is ignored until that status has been read.
- R7: While a status is held, a read returns the status byte and consumes it without moving the byte pointer. This holds even if a count was latched earlier. The following one or two reads return the held count, and later reads return the live count.
- R8: In the two-byte format every count read, held or live, toggles the byte pointer, so reads alternate low byte then high byte. A held count is released only by the high-byte read.
- R9: A `prog_i` pulse releases a held count and returns the byte pointer to the low byte.
- R10: In a one-byte format (01 or 10) a single count read releases a held count, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| live_cnt_i | input | 16 | Current value of the counting element |
| out_lvl_i | input | 1 | Present level of the channel output |
| null_cnt_i | input | 1 | Null-count flag from the channel |
| cfg_i | input | 6 | Stored configuration bits (format in 5..4) |
| latch_cnt_i | input | 1 | One-cycle request to snapshot the count |
| latch_sts_i | input | 1 | One-cycle request to snapshot the status |
| rd_i | input | 1 | One-cycle read of this channel; the byte on `rd_data_o` in that cycle is the one consumed |
| prog_i | input | 1 | One-cycle strobe marking a new configuration word for this channel |
| rd_data_o | output | 8 | Byte presented for a read |

## Verification
Directed sequences separate the four ways a read can be sourced: a live read, a count snapshot, a status snapshot, and both snapshots together latched in either order. Each is repeated with extra latch strobes to show that the first capture wins. Reads in the two-byte, low-only and high-only formats show whether the pointer and the release follow the format rather than the read count alone. A program strobe between the two bytes checks that the pointer is reset. Long random mixes of strobes, live values and formats are then compared against a bench model, which exposes ordering faults when strobes land on adjacent cycles.

// File: rtl/cnt_rb_pkg.sv
// Shared widths and format codes for the channel readback path.
// Assumes a count of exactly two bytes.
package cnt_rb_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CFG_W  = 6;
    localparam int STS_W  = CFG_W + 2;

    // Byte format field of the configuration bits
    typedef enum logic [1:0] {
        FMT_CMD  = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_WORD = 2'b11
    } rw_fmt_e;

    // True when the format reads two bytes (00 is never stored; treated as two-byte)
    function automatic logic fmt_is_word(input rw_fmt_e f);
        return (f == FMT_WORD) || (f == FMT_CMD);
    endfunction
endpackage

// File: rtl/cnt_rb_byte_seq.sv
// Byte pointer for count reads.
// Toggles on each count read in the two-byte format, is cleared by a program
// strobe, and tells the hold logic which read finishes a count.
// Assumes reads consumed by a held status are flagged by sts_busy_i.
module cnt_rb_byte_seq
    import cnt_rb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rw_fmt_e fmt_i,
    input  logic    rd_i,
    input  logic    prog_i,
    input  logic    sts_busy_i,
    output logic    hi_sel_o,
    output logic    last_o
);
    logic ptr_q;
    logic word;

    assign word = fmt_is_word(fmt_i);

    // Pointer: clear on program, step on each two-byte count read
    always_ff @(posedge clk) begin
        if (!rst_n)                            ptr_q <= 1'b0;
        else if (prog_i)                       ptr_q <= 1'b0;
        else if (rd_i && !sts_busy_i && word)  ptr_q <= ~ptr_q;
    end

    // Byte select and end-of-count decode
    always_comb begin
        hi_sel_o = word ? ptr_q : (fmt_i == FMT_HI);
        last_o   = word ? ptr_q : 1'b1;
    end

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !sts_busy_i && word && !prog_i) |=> (ptr_q != $past(ptr_q)));

    // R10
    ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word && !prog_i) |=> $stable(ptr_q));
endmodule

// File: rtl/cnt_rb_count_hold.sv
// Count output latch: follows the live count, and freezes on the first latch
// request until released by the final read byte or by a program strobe.
// Later latch requests are ignored while a value is held.
module cnt_rb_count_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         latch_i,
    input  logic         release_i,
    input  logic         prog_i,
    output logic [W-1:0] ol_o,
    output logic         held_o
);
    logic [W-1:0] hold_q;
    logic         held_q;

    // Snapshot control: program, then release, then first latch wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (prog_i || release_i) begin
            held_q <= 1'b0;
        end else if (latch_i && !held_q) begin
            held_q <= 1'b1;
            hold_q <= live_i;
        end
    end

    // Output latch view: frozen value or the live count
    assign ol_o   = held_q ? hold_q : live_i;
    assign held_o = held_q;

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !prog_i && !release_i) |=> (held_q && $stable(hold_q)));

    // R3
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && !held_q && !prog_i && !release_i) |=> (held_q && hold_q == $past(live_i)));
endmodule

// File: rtl/cnt_rb_status_hold.sv
// Status latch: captures the status byte on the first request, is consumed by
// the next read of the channel, and ignores requests while full.
module cnt_rb_status_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sts_i,
    input  logic         latch_i,
    input  logic         consume_i,
    output logic [W-1:0] sts_o,
    output logic         held_o
);
    logic [W-1:0] sts_q;
    logic         held_q;

    // Status snapshot: consume on read, capture only when empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            sts_q  <= '0;
        end else if (consume_i) begin
            held_q <= 1'b0;
        end else if (latch_i && !held_q) begin
            held_q <= 1'b1;
            sts_q  <= sts_i;
        end
    end

    assign sts_o  = sts_q;
    assign held_o = held_q;

    // R6
    sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !consume_i) |=> (held_q && $stable(sts_q)));
endmodule

// File: rtl/cnt_readback_path.sv
// Readback path of one timer channel: count snapshot, status snapshot and
// byte sequencing, producing the byte a read of the channel returns.
// Assumes strobes are single-cycle pulses in the clk domain; rd_data_o is
// valid combinationally in the cycle rd_i is asserted.
module cnt_readback_path
    import cnt_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] live_cnt_i,
    input  logic             out_lvl_i,
    input  logic             null_cnt_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             latch_cnt_i,
    input  logic             latch_sts_i,
    input  logic             rd_i,
    input  logic             prog_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    rw_fmt_e          fmt;
    logic             sts_held;
    logic [STS_W-1:0] sts_q;
    logic             cnt_held;
    logic [CNT_W-1:0] ol;
    logic             hi_sel;
    logic             last;
    logic             cnt_release;
    logic             sts_consume;
    logic [STS_W-1:0] sts_now;

    assign fmt         = rw_fmt_e'(cfg_i[5:4]);
    assign sts_now     = {out_lvl_i, null_cnt_i, cfg_i};
    assign sts_consume = rd_i && sts_held;
    assign cnt_release = rd_i && !sts_held && last;

    cnt_rb_byte_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt),
        .rd_i       (rd_i),
        .prog_i     (prog_i),
        .sts_busy_i (sts_held),
        .hi_sel_o   (hi_sel),
        .last_o     (last)
    );

    cnt_rb_count_hold #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_i    (live_cnt_i),
        .latch_i   (latch_cnt_i),
        .release_i (cnt_release),
        .prog_i    (prog_i),
        .ol_o      (ol),
        .held_o    (cnt_held)
    );

    cnt_rb_status_hold #(.W(STS_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_i     (sts_now),
        .latch_i   (latch_sts_i),
        .consume_i (sts_consume),
        .sts_o     (sts_q),
        .held_o    (sts_held)
    );

    // Read mux: status first, then the selected count byte
    always_comb begin
        if (sts_held)    rd_data_o = sts_q;
        else if (hi_sel) rd_data_o = ol[CNT_W-1:BYTE_W];
        else             rd_data_o = ol[BYTE_W-1:0];
    end

    // R9
    prog_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> !cnt_held);

    // R7
    sts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_held && rd_i) |=> !sts_held);
endmodule

// File: tb/cnt_readback_path_bench.sv
`timescale 1ns/1ps
module cnt_readback_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] live = '0;
    logic        outl = 1'b0;
    logic        nullf = 1'b0;
    logic [5:0]  cfg = 6'b110100;
    logic        lc = 1'b0, ls = 1'b0, rd = 1'b0, prog = 1'b0;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit          m_cnt_held, m_sts_held, m_ptr;
    logic [15:0] m_cnt;
    logic [7:0]  m_sts;

    always #2.5 clk = ~clk;

    cnt_readback_path u_cnt_readback_path (
        .clk(clk), .rst_n(rst_n), .live_cnt_i(live), .out_lvl_i(outl),
        .null_cnt_i(nullf), .cfg_i(cfg), .latch_cnt_i(lc), .latch_sts_i(ls),
        .rd_i(rd), .prog_i(prog), .rd_data_o(rd_data)
    );

    function automatic bit is_word(input logic [5:0] c);
        return c[5] == c[4];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] lv, input logic [5:0] c);
        logic [15:0] ol;
        bit hi;
        if (m_sts_held) return m_sts;
        ol = m_cnt_held ? m_cnt : lv;
        hi = is_word(c) ? m_ptr : (c[5:4] == 2'b10);
        return hi ? ol[15:8] : ol[7:0];
    endfunction

    task automatic model_reset();
        m_cnt_held = 0; m_sts_held = 0; m_ptr = 0; m_cnt = '0; m_sts = '0;
    endtask

    task automatic model_step();
        bit w, rel, cons;
        w    = is_word(cfg);
        cons = rd && m_sts_held;
        rel  = rd && !m_sts_held && (w ? m_ptr : 1'b1);
        if (prog || rel)                m_cnt_held = 0;
        else if (lc && !m_cnt_held)     begin m_cnt_held = 1; m_cnt = live; end
        if (cons)                       m_sts_held = 0;
        else if (ls && !m_sts_held)     begin m_sts_held = 1; m_sts = {outl, nullf, cfg}; end
        if (prog)                       m_ptr = 0;
        else if (rd && !cons && w)      m_ptr = ~m_ptr;
    endtask

    // one cycle: drive at negedge, compare, advance model at posedge
    task automatic cyc(input logic [15:0] lv, input logic o, input logic n,
                       input logic [5:0] c, input logic l_c, input logic l_s,
                       input logic r, input logic p, input string tag);
        logic [7:0] e;
        @(negedge clk);
        live = lv; outl = o; nullf = n; cfg = c; lc = l_c; ls = l_s; rd = r; prog = p;
        #1;
        e = exp_byte(lv, c);
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, e);
        end
        @(posedge clk);
        model_step();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    localparam logic [5:0] W2 = 6'b110100;
    localparam logic [5:0] LO = 6'b010100;
    localparam logic [5:0] HI = 6'b100100;

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state shows live low byte
        cyc(16'h1234, 0, 0, W2, 0, 0, 0, 0, "R1 reset");
        // R2: live follows
        cyc(16'hABCD, 0, 0, W2, 0, 0, 0, 0, "R2 live follow");
        // R8: live two-byte reads alternate
        cyc(16'hABCD, 0, 0, W2, 0, 0, 1, 0, "R8 live lsb");
        cyc(16'hABCD, 0, 0, W2, 0, 0, 1, 0, "R8 live msb");
        // R3: latch then live moves, reads return snapshot, then live
        cyc(16'h5511, 0, 0, W2, 1, 0, 0, 0, "R3 latch");
        cyc(16'h7788, 0, 0, W2, 0, 0, 1, 0, "R3 held lsb");
        cyc(16'h99AA, 0, 0, W2, 0, 0, 1, 0, "R3 held msb");
        cyc(16'hC3D4, 0, 0, W2, 0, 0, 0, 0, "R3 back to live");
        // R4: repeated latch ignored
        cyc(16'h0102, 0, 0, W2, 1, 0, 0, 0, "R4 first latch");
        cyc(16'h0304, 0, 0, W2, 1, 0, 0, 0, "R4 second latch");
        cyc(16'h0506, 0, 0, W2, 0, 0, 1, 0, "R4 lsb");
        cyc(16'h0506, 0, 0, W2, 0, 0, 1, 0, "R4 msb");
        // R5/R7: status then count, status first
        cyc(16'h0A0B, 1, 0, W2, 0, 1, 0, 0, "R5 latch status");
        cyc(16'h0A0B, 0, 1, W2, 1, 0, 0, 0, "R7 latch count");
        cyc(16'hFFFF, 0, 1, W2, 0, 0, 1, 0, "R5 status byte");
        cyc(16'hFFFF, 0, 1, W2, 0, 0, 1, 0, "R7 count lsb");
        cyc(16'hFFFF, 0, 1, W2, 0, 0, 1, 0, "R7 count msb");
        cyc(16'h1357, 0, 1, W2, 0, 0, 1, 0, "R7 live after");
        cyc(16'h1357, 0, 1, W2, 0, 0, 1, 0, "R7 live msb");
        // R6: repeated status latch ignored; count first then status
        cyc(16'h2468, 0, 1, W2, 1, 0, 0, 0, "R7 count first");
        cyc(16'h2468, 1, 0, W2, 0, 1, 0, 0, "R6 status latch");
        cyc(16'h2468, 0, 1, W2, 0, 1, 0, 0, "R6 repeat ignored");
        cyc(16'h0000, 0, 1, W2, 0, 0, 1, 0, "R6 first status read");
        cyc(16'h0000, 0, 1, W2, 0, 0, 1, 0, "R7 held lsb");
        cyc(16'h0000, 0, 1, W2, 0, 0, 1, 0, "R7 held msb");
        // R9: program between bytes releases and resets pointer
        cyc(16'hBEEF, 0, 0, W2, 1, 0, 0, 0, "R9 latch");
        cyc(16'hBEEF, 0, 0, W2, 0, 0, 1, 0, "R9 lsb");
        cyc(16'hCAFE, 0, 0, W2, 0, 0, 0, 1, "R9 program");
        cyc(16'hCAFE, 0, 0, W2, 0, 0, 1, 0, "R9 live lsb after program");
        cyc(16'hCAFE, 0, 0, W2, 0, 0, 1, 0, "R9 live msb");
        // R10: one-byte formats
        cyc(16'h4321, 0, 0, LO, 0, 0, 0, 1, "R10 program lo");
        cyc(16'h4321, 0, 0, LO, 1, 0, 0, 0, "R10 latch lo");
        cyc(16'h8765, 0, 0, LO, 0, 0, 1, 0, "R10 held lo");
        cyc(16'h8765, 0, 0, LO, 0, 0, 1, 0, "R10 live lo");
        cyc(16'h8765, 0, 0, HI, 0, 0, 0, 1, "R2 program hi");
        cyc(16'h8765, 0, 0, HI, 1, 0, 0, 0, "R10 latch hi");
        cyc(16'h1111, 0, 0, HI, 0, 0, 1, 0, "R10 held hi");
        cyc(16'h1111, 0, 0, HI, 0, 0, 1, 0, "R10 live hi");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] c;
            logic p;
            p = ($urandom % 25) == 0;
            c = cfg;
            if (p) c = {2'($urandom), 4'($urandom)};
            cyc(16'($urandom), 1'($urandom), 1'($urandom), c,
                ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0, p,
                "RND R3 R7 R8");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule